// File: doc/BRIEF.md
# Two-Wire Slave Command Front End for a Dual Potentiometer

This block is the serial front end of a dual digital-potentiometer register file. It watches an open-drain two-wire bus with a fast system clock, finds start and stop conditions, and accepts a transaction with a fixed shape. An 8-bit device address comes first, then a command byte, then, for some commands, one data byte. The slave pulls SDA low on the ninth clock of each byte it accepts. Commands that carry a data byte deliver it to the register block. Commands that fetch a byte take it from the register block and shift it out.

Toward the register block the slave produces a one-cycle request that names the operation, the potentiometer (0 or 1), the register index (0 to 3) and the write data. The register block returns the read byte on `rd_data`. On the bus side the slave never drives SDA high. `sda_oe` high means the pad pulls the line low, and a released line reads high through the pull-up.

Top module: `tw_pot_slave`

## Requirements
- R1: A start condition (SDA falls while SCL is high) begins reception of the address byte. Out of reset, and before any start, the slave ignores bus traffic: `sda_oe` and `req_valid` stay low.
- R2: A stop condition (SDA rises while SCL is high) returns the slave to idle with SDA released.
- R3: `sda_oe` changes only while SCL is low. It never changes during a high phase of SCL.
- R4: The address byte is received MSB first. It must equal {DEV_ID, strap_addr}, with DEV_ID = 4'b0101 by default in bits [7:4] and the strap inputs in bits [3:0]. On a match the slave pulls SDA low on the ninth clock. On a mismatch it does not acknowledge, issues no request, and ignores the bus until the next start.
- R5: The command byte holds the opcode in bits [7:4], the register index in bits [3:2] and the potentiometer select in bit [0]. Bit [1] is ignored. The valid opcodes are 0x1 (stored register to wiper), 0x2 (wiper to stored register), 0x3 (step up), 0x4 (step down), 0x9 (read wiper), 0xA (write wiper), 0xB (read stored register) and 0xC (write stored register). A valid opcode is acknowledged. Any other opcode is not acknowledged and produces no request.
- R6: For opcodes 0x1 to 0x4, exactly one `req_valid` pulse carrying the opcode, register index and potentiometer select follows the command byte, and no data byte is expected.
- R7: For the write opcodes (0xA, 0xC), no request is issued after the command byte. The following data byte is acknowledged and then exactly one request is issued, with that byte on `req_wdata`.
- R8: For the read opcodes (0x9, 0xB), exactly one request follows the command byte. `rd_data` is captured at the SCL falling edge that ends the command acknowledge and is shifted out MSB first, with each bit changing after an SCL falling edge. SDA is released after the eighth bit, and the master's acknowledge is ignored.
- R9: A start received in the middle of any byte abandons the current transaction without a request and restarts address reception.
- R10: Bytes that follow the last phase of a transaction are not acknowledged and produce no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad (wired-AND level) |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| strap_addr | input | STRAP_W (4) | Low bits of the device address |
| req_valid | output | 1 | One-cycle request strobe to the register block |
| req_op | output | 4 | Opcode of the request |
| req_pot | output | 1 | Potentiometer select |
| req_rsel | output | 2 | Register index |
| req_wdata | output | 8 | Write data (write opcodes only) |
| rd_data | input | 8 | Read byte returned by the register block |

## Verification
The assertions assume a well-behaved master. SDA moves only while SCL is low, except for start and stop. The master never makes a start or stop while the slave is pulling SDA low. Every SCL high or low phase lasts well beyond the synchronizer delay, so the slave's response to a falling edge lands inside the low phase that follows. The bench keeps to these rules: each quarter of a bit lasts eight system clocks, the line is modelled as a wired-AND of master and slave, and starts and stops are issued only after the slave has released SDA. Random transactions mix matching and mismatched addresses with all sixteen opcodes, and directed cases add aborted bytes and surplus bytes.

// File: rtl/tw_pot_pkg.sv
package tw_pot_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    localparam logic [3:0] OP_STORE_TO_WIPER = 4'h1;
    localparam logic [3:0] OP_WIPER_TO_STORE = 4'h2;
    localparam logic [3:0] OP_STEP_UP        = 4'h3;
    localparam logic [3:0] OP_STEP_DOWN      = 4'h4;
    localparam logic [3:0] OP_RD_WIPER       = 4'h9;
    localparam logic [3:0] OP_WR_WIPER       = 4'hA;
    localparam logic [3:0] OP_RD_STORE       = 4'hB;
    localparam logic [3:0] OP_WR_STORE       = 4'hC;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } tw_state_e;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_WRITE,
        CLS_READ,
        CLS_BAD
    } op_class_e;

    typedef struct packed {
        logic [3:0]        op;
        logic [1:0]        rsel;
        logic              pot;
        logic [BYTE_W-1:0] wdata;
    } pot_req_t;

    function automatic op_class_e op_class(input logic [3:0] op);
        op_class_e c;
        case (op)
            OP_STORE_TO_WIPER, OP_WIPER_TO_STORE,
            OP_STEP_UP, OP_STEP_DOWN:          c = CLS_NONE;
            OP_WR_WIPER, OP_WR_STORE:          c = CLS_WRITE;
            OP_RD_WIPER, OP_RD_STORE:          c = CLS_READ;
            default:                           c = CLS_BAD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/tw_bus_cond.sv
module tw_bus_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

    // R2/R1: start and stop never appear together
    a_r2_cond_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(start_det && stop_det));
endmodule

// File: rtl/tw_cmd_decode.sv
module tw_cmd_decode
    import tw_pot_pkg::*;
(
    input  logic [3:0] opcode,
    output op_class_e  cls
);
    assign cls = op_class(opcode);
endmodule

// File: rtl/tw_pot_slave.sv
module tw_pot_slave
    import tw_pot_pkg::*;
#(
    parameter int                 STRAP_W     = 4,
    parameter logic [7-STRAP_W:0] DEV_ID      = 4'b0101,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_addr,
    output logic               req_valid,
    output logic [3:0]         req_op,
    output logic               req_pot,
    output logic [1:0]         req_rsel,
    output logic [BYTE_W-1:0]  req_wdata,
    input  logic [BYTE_W-1:0]  rd_data
);
    localparam int          NLINES   = 2;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] sync_lines;
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        tw_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[g]),
            .dout (sync_lines[g])
        );
    end

    assign scl_s = sync_lines[0];
    assign sda_s = sync_lines[1];

    tw_bus_cond u_cond (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tw_state_e           state;
    logic [CNT_W-1:0]    bit_cnt;
    logic [BYTE_W-1:0]   rx_shift;
    logic [BYTE_W-2:0]   tx_rest;
    logic                oe_q;
    op_class_e           cmd_cls_q;
    op_class_e           dec_cls;
    pot_req_t            req_q;
    logic                req_v;
    logic                byte_ok;

    tw_cmd_decode u_dec (
        .opcode (rx_shift[7:4]),
        .cls    (dec_cls)
    );

    always_comb begin
        case (state)
            ST_ADDR:  byte_ok = (rx_shift == {DEV_ID, strap_addr});
            ST_CMD:   byte_ok = (dec_cls != CLS_BAD);
            ST_WDATA: byte_ok = 1'b1;
            default:  byte_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_shift  <= '0;
            tx_rest   <= '0;
            oe_q      <= 1'b0;
            cmd_cls_q <= CLS_BAD;
            req_q     <= '0;
            req_v     <= 1'b0;
        end else begin
            req_v <= 1'b0;
            if (stop_det) begin
                state <= ST_IDLE;
                oe_q  <= 1'b0;
            end else if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                oe_q    <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise && bit_cnt != LAST_BIT) begin
                            rx_shift <= {rx_shift[BYTE_W-2:0], sda_s};
                            bit_cnt  <= bit_cnt + CNT_W'(1);
                        end else if (scl_fall && bit_cnt == LAST_BIT) begin
                            bit_cnt <= '0;
                            if (!byte_ok) begin
                                state <= ST_IDLE;
                            end else begin
                                oe_q <= 1'b1;
                                if (state == ST_ADDR) begin
                                    state <= ST_ADDR_ACK;
                                end else if (state == ST_CMD) begin
                                    state      <= ST_CMD_ACK;
                                    cmd_cls_q  <= dec_cls;
                                    req_q.op   <= rx_shift[7:4];
                                    req_q.rsel <= rx_shift[3:2];
                                    req_q.pot  <= rx_shift[0];
                                    req_q.wdata <= '0;
                                    req_v      <= (dec_cls != CLS_WRITE);
                                end else begin
                                    state       <= ST_WDATA_ACK;
                                    req_q.wdata <= rx_shift;
                                    req_v       <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            oe_q  <= 1'b0;
                            state <= ST_CMD;
                        end
                    end
                    ST_CMD_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            case (cmd_cls_q)
                                CLS_WRITE: begin
                                    oe_q  <= 1'b0;
                                    state <= ST_WDATA;
                                end
                                CLS_READ: begin
                                    tx_rest <= rd_data[BYTE_W-2:0];
                                    oe_q    <= ~rd_data[BYTE_W-1];
                                    state   <= ST_RDATA;
                                end
                                default: begin
                                    oe_q  <= 1'b0;
                                    state <= ST_IDLE;
                                end
                            endcase
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            oe_q  <= 1'b0;
                            state <= ST_IDLE;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end else if (scl_fall) begin
                            if (bit_cnt == LAST_BIT) begin
                                oe_q  <= 1'b0;
                                state <= ST_RDATA_ACK;
                            end else begin
                                oe_q    <= ~tx_rest[BYTE_W-2];
                                tx_rest <= {tx_rest[BYTE_W-3:0], 1'b0};
                            end
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (scl_fall) begin
                            state <= ST_IDLE;
                        end
                    end
                    default: begin
                        state <= ST_IDLE;
                        oe_q  <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sda_oe    = oe_q;
    assign req_valid = req_v;
    assign req_op    = req_q.op;
    assign req_pot   = req_q.pot;
    assign req_rsel  = req_q.rsel;
    assign req_wdata = req_q.wdata;

    // R1: a start always restarts address reception with SDA released
    a_r1_start_restarts: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (state == ST_ADDR && !sda_oe));

    // R2: a stop always leaves the slave idle and released
    a_r2_stop_idles: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    // R3: the pull-down holds still across a high phase of SCL
    a_r3_oe_steady_high: assert property (@(posedge clk) disable iff (rst)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R5: the line is pulled only while acknowledging or sending
    a_r5_oe_in_drive_state: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (state == ST_ADDR_ACK || state == ST_CMD_ACK ||
                    state == ST_WDATA_ACK || state == ST_RDATA));

    // R6: each request strobe lasts one cycle
    a_r6_req_single: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);

    // R7: a write request appears only once its data byte is taken
    a_r7_write_after_data: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_class(req_op) == CLS_WRITE) |-> state == ST_WDATA_ACK);
endmodule

// File: tb/tw_pot_slave_tb_top.sv
module tw_pot_slave_tb_top;
    localparam int Q = 8;
    localparam logic [7:0] MY_ADDR = 8'h5A;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [3:0] strap = 4'b1010;
    logic       req_valid;
    logic [3:0] req_op;
    logic       req_pot;
    logic [1:0] req_rsel;
    logic [7:0] req_wdata;
    logic [7:0] rd_data = 8'h00;

    assign sda_line = sda_m & ~sda_oe;

    tw_pot_slave dut_i (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .strap_addr (strap),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_pot    (req_pot),
        .req_rsel   (req_rsel),
        .req_wdata  (req_wdata),
        .rd_data    (rd_data)
    );

    int total = 0;
    int bad   = 0;
    int req_cnt = 0;
    logic [3:0] m_op;
    logic       m_pot;
    logic [1:0] m_rsel;
    logic [7:0] m_wd;
    logic [7:0] salt = 8'h00;
    int hi_run = 0;
    int r3_viol = 0;
    logic oe_prev = 1'b0;

    function automatic logic [7:0] rd_pattern(input logic [3:0] op, input logic pot,
                                              input logic [1:0] rs, input logic [7:0] s);
        return {pot, rs, op, 1'b1} ^ s;
    endfunction

    // 0: no data, 1: write, 2: read, 3: invalid
    function automatic int exp_class(input logic [3:0] op);
        case (op)
            4'h1, 4'h2, 4'h3, 4'h4: return 0;
            4'hA, 4'hC:             return 1;
            4'h9, 4'hB:             return 2;
            default:                return 3;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst && req_valid) begin
            req_cnt++;
            m_op = req_op; m_pot = req_pot; m_rsel = req_rsel; m_wd = req_wdata;
            if (exp_class(req_op) == 2) rd_data = rd_pattern(req_op, req_pot, req_rsel, salt);
        end
        if (scl_m) hi_run++; else hi_run = 0;
        if (!rst && hi_run > 5 && sda_oe != oe_prev) r3_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input bit b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!mack);
    endtask

    task automatic run_txn(input logic [7:0] addr, input logic [7:0] cmd,
                           input logic [7:0] wd, input bit extra);
        bit a;
        int base;
        int cls;
        logic [7:0] v;
        salt = 8'($urandom);
        base = req_cnt;
        bus_start();
        send_byte(addr, a);
        chk(a == (addr == MY_ADDR), "R4 address ack", int'(a), int'(addr == MY_ADDR));
        if (addr != MY_ADDR) begin
            send_byte(cmd, a);
            chk(!a, "R4 ignored after mismatch", int'(a), 0);
            chk(req_cnt == base, "R4 no request after mismatch", req_cnt - base, 0);
            bus_stop();
            chk(!sda_oe, "R2 released after stop", int'(sda_oe), 0);
            return;
        end
        send_byte(cmd, a);
        cls = exp_class(cmd[7:4]);
        chk(a == (cls != 3), "R5 command ack", int'(a), int'(cls != 3));
        case (cls)
            0: begin
                chk(req_cnt == base + 1, "R6 request count", req_cnt - base, 1);
                chk({m_op, m_rsel, m_pot} == {cmd[7:4], cmd[3:2], cmd[0]},
                    "R6 request fields", int'({m_op, m_rsel, m_pot}),
                    int'({cmd[7:4], cmd[3:2], cmd[0]}));
            end
            1: begin
                chk(req_cnt == base, "R7 no request before data", req_cnt - base, 0);
                send_byte(wd, a);
                chk(a, "R7 data ack", int'(a), 1);
                chk(req_cnt == base + 1, "R7 request count", req_cnt - base, 1);
                chk({m_op, m_rsel, m_pot, m_wd} == {cmd[7:4], cmd[3:2], cmd[0], wd},
                    "R7 request fields", int'({m_op, m_rsel, m_pot, m_wd}),
                    int'({cmd[7:4], cmd[3:2], cmd[0], wd}));
                if (extra) begin
                    send_byte(8'($urandom), a);
                    chk(!a, "R10 surplus byte not acked", int'(a), 0);
                    chk(req_cnt == base + 1, "R10 no surplus request", req_cnt - base, 1);
                end
            end
            2: begin
                chk(req_cnt == base + 1, "R8 request count", req_cnt - base, 1);
                chk({m_op, m_rsel, m_pot} == {cmd[7:4], cmd[3:2], cmd[0]},
                    "R8 request fields", int'({m_op, m_rsel, m_pot}),
                    int'({cmd[7:4], cmd[3:2], cmd[0]}));
                recv_byte(1'b0, v);
                chk(v == rd_pattern(cmd[7:4], cmd[0], cmd[3:2], salt), "R8 read byte",
                    int'(v), int'(rd_pattern(cmd[7:4], cmd[0], cmd[3:2], salt)));
                if (extra) begin
                    send_byte(8'($urandom), a);
                    chk(!a, "R10 byte after read not acked", int'(a), 0);
                end
            end
            default: begin
                chk(req_cnt == base, "R5 no request for bad opcode", req_cnt - base, 0);
            end
        endcase
        bus_stop();
        chk(!sda_oe, "R2 released after stop", int'(sda_oe), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit a;
        int base;
        logic [7:0] addr;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!sda_oe, "R1 reset sda_oe", int'(sda_oe), 0);
        chk(!req_valid, "R1 reset req_valid", int'(req_valid), 0);

        // R1: traffic before any start is ignored
        scl_m = 1'b0; wq();
        send_byte(MY_ADDR, a);
        chk(!a, "R1 no ack without start", int'(a), 0);
        send_byte(8'hA0, a);
        chk(req_cnt == 0, "R1 no request without start", req_cnt, 0);
        bus_stop();

        // directed: every valid opcode class, both pots, extreme indices
        run_txn(MY_ADDR, 8'h3D, 8'h00, 1'b0);
        run_txn(MY_ADDR, 8'h40, 8'h00, 1'b0);
        run_txn(MY_ADDR, 8'hAF, 8'hFF, 1'b1);
        run_txn(MY_ADDR, 8'hC2, 8'h00, 1'b0);
        run_txn(MY_ADDR, 8'h9C, 8'h00, 1'b1);
        run_txn(MY_ADDR, 8'hB1, 8'h00, 1'b0);
        run_txn(MY_ADDR, 8'h00, 8'h00, 1'b0);
        run_txn(MY_ADDR, 8'hF5, 8'h00, 1'b0);
        run_txn(8'h5B, 8'hA1, 8'h11, 1'b0);
        run_txn(8'hDA, 8'h31, 8'h11, 1'b0);

        // R9: start in the middle of the address byte
        base = req_cnt;
        bus_start();
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        run_txn(MY_ADDR, 8'hC9, 8'h6B, 1'b0);
        chk(req_cnt == base + 1, "R9 abort mid address", req_cnt - base, 1);

        // R9: start in the middle of a write command byte
        base = req_cnt;
        bus_start();
        send_byte(MY_ADDR, a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        run_txn(MY_ADDR, 8'h2E, 8'h00, 1'b0);
        chk(req_cnt == base + 1, "R9 abort mid command", req_cnt - base, 1);
        chk(m_op == 4'h2, "R9 request from restarted command", int'(m_op), 2);

        // R9: start in the middle of a data byte
        base = req_cnt;
        bus_start();
        send_byte(MY_ADDR, a);
        send_byte(8'hA4, a);
        put_bit(1'b0); put_bit(1'b0);
        run_txn(MY_ADDR, 8'h41, 8'h00, 1'b0);
        chk(req_cnt == base + 1, "R9 abort mid data", req_cnt - base, 1);

        // random mix
        for (int n = 0; n < 36; n++) begin
            if ($urandom_range(0, 9) < 8) addr = MY_ADDR;
            else addr = MY_ADDR ^ 8'(1 << $urandom_range(0, 7));
            run_txn(addr, 8'($urandom), 8'($urandom), 1'($urandom_range(0, 1)));
        end

        chk(r3_viol == 0, "R3 sda_oe moved while SCL high", r3_viol, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule